// File: doc/BRIEF.md
# Recirculating Echo Delay Line

This block adds a simple echo to a stream of signed audio samples. It keeps a circular store of past samples sized from the sample rate and the wanted delay. When a sample strobe arrives, the block reads the stored sample at the current position. It blends the new sample with that stored one using a weight supplied with the strobe. It then writes the blend back into the ring, presents it at the output and moves the pointer on, wrapping at the end of the store. Because the blend goes back into the ring, every echo feeds the next one, and the echoes fade away geometrically.

A pitch option separates the read position from the write position. The read position then steps two locations per sample while the write position steps one. Played back, this gives a crude octave-up shift. Clicks where the two positions pass each other are left audible.

A three-state controller runs each sample. `ST_IDLE` waits for a strobe and latches the sample, the weight and the mode (transition `accept`). `ST_FETCH` reads the stored sample (transition `fetched`, which is unconditional). `ST_BLEND` writes the blend back, registers the output and moves the pointers (transition `retire`, back to `ST_IDLE`).

Top module: `echo_ring`

## Requirements
- R1: After reset, `out_valid` and `out_sample` are 0, both pointers are at location 0, and every location of the ring reads as 0 (silence).
- R2: A strobe accepted at a clock edge produces exactly one `out_valid` pulse, one cycle wide, that becomes visible after the third rising edge, counting the accepting edge as the first.
- R3: The output equals floor((in·k + old·(256−k) + 128) / 256), clamped to the signed 16-bit range. Here `in` and `old` are signed 16-bit values and k is the unsigned 8-bit value on `mix_k`.
- R4: The blended value is written back to the location it was read from in normal mode, so it returns as `old` when the pointer next reaches that location.
- R5: The write pointer advances by one per accepted sample and wraps from DEPTH−1 to 0. DEPTH is SAMPLE_HZ·DELAY_MS/1000.
- R6: `mix_k` and `pitch_en` are sampled only together with an accepted strobe, so each sample can use a different weight.
- R7: A strobe that arrives while a sample is still being processed (the two cycles after the accepting edge) is ignored. It produces no output and moves no pointer.
- R8: When `pitch_en` is 1, the old value is read at the read pointer and the blend is written at the write pointer. The read pointer then advances by two, modulo DEPTH. When `pitch_en` is 0, the read pointer is set to the next write position.
- R9: While no strobe arrives, the pointers and the ring contents stay unchanged and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Incoming signed sample |
| mix_k | input | 8 | Weight of the incoming sample, in units of 1/256 |
| pitch_en | input | 1 | Select the split-pointer pitch mode for this sample |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_sample | output | 16 | Blended signed sample |

## Verification
The bench builds the block with SAMPLE_HZ=1000 and DELAY_MS=6, which gives a six-entry ring. This length is not a power of two, so the explicit wrap logic is exercised rather than a bit-width overflow. It also means a blended value comes back as `old` after only six samples, so several recirculation passes and pointer wraps fit into a short run. With the short ring, the double-step read pointer in pitch mode overtakes the write pointer within a few samples, so the pointer-crossing case is reached as well.

// File: rtl/echo_pkg.sv
package echo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_BLEND = 2'd2
    } echo_state_t;

    localparam int SAMPLE_W = 16;
    localparam int WEIGHT_W = 8;
endpackage

// File: rtl/echo_fsm.sv
module echo_fsm
    import echo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic capture,
    output logic fetch,
    output logic commit,
    output logic idle
);
    echo_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx   = st;
        capture = 1'b0;
        fetch   = 1'b0;
        commit  = 1'b0;
        idle    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                idle = 1'b1;
                if (in_valid) begin
                    capture = 1'b1;          // accept
                    st_nx   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                fetch = 1'b1;                // fetched
                st_nx = ST_BLEND;
            end
            ST_BLEND: begin
                commit = 1'b1;               // retire
                st_nx  = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/echo_mixer.sv
module echo_mixer #(
    parameter int DW = 16,
    parameter int KW = 8
) (
    input  logic signed [DW-1:0] fresh,
    input  logic signed [DW-1:0] stale,
    input  logic        [KW-1:0] k,
    output logic signed [DW-1:0] mix
);
    localparam int ACC_W = DW + KW + 2;
    localparam int ONE   = 1 << KW;
    localparam int HALF  = ONE / 2;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [KW+1:0]    w_new, w_old;
    logic signed [ACC_W-1:0] acc, scaled;

    always_comb begin
        w_new  = signed'({2'b00, k});
        w_old  = signed'((KW + 2)'(ONE)) - w_new;
        acc    = ACC_W'(fresh) * ACC_W'(w_new)
               + ACC_W'(stale) * ACC_W'(w_old)
               + ACC_W'(HALF);
        scaled = acc >>> KW;
        if (scaled > MAXV)      mix = MAXV[DW-1:0];
        else if (scaled < MINV) mix = MINV[DW-1:0];
        else                    mix = scaled[DW-1:0];
    end
endmodule

// File: rtl/echo_store.sv
module echo_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pitch,
    input  logic                 fetch,
    input  logic                 commit,
    input  logic signed [DW-1:0] wdata,
    output logic signed [DW-1:0] stale,
    output logic        [AW-1:0] wr_ptr,
    output logic        [AW-1:0] rd_ptr
);
    logic signed [DW-1:0] ring [DEPTH];
    logic [AW-1:0] raddr, wr_nx, rd_skip;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [1:0] s);
        logic [AW:0] sum, wrapped;
        sum     = {1'b0, p} + (AW + 1)'(s);
        wrapped = sum - (AW + 1)'(DEPTH);
        return (sum >= (AW + 1)'(DEPTH)) ? wrapped[AW-1:0] : sum[AW-1:0];
    endfunction

    always_comb begin
        raddr   = pitch ? rd_ptr : wr_ptr;
        wr_nx   = step_ptr(wr_ptr, 2'd1);
        rd_skip = step_ptr(rd_ptr, 2'd2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            stale  <= '0;
        end else begin
            if (fetch) stale <= ring[raddr];
            if (commit) begin
                ring[wr_ptr] <= wdata;
                wr_ptr       <= wr_nx;
                rd_ptr       <= pitch ? rd_skip : wr_nx;
            end
        end
    end
endmodule

// File: rtl/echo_ring.sv
module echo_ring #(
    parameter int SAMPLE_HZ = 32000,
    parameter int DELAY_MS  = 64,
    parameter int DW        = 16,
    parameter int KW        = 8,
    localparam int DEPTH    = SAMPLE_HZ * DELAY_MS / 1000,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [KW-1:0] mix_k,
    input  logic          pitch_en,
    output logic          out_valid,
    output logic [DW-1:0] out_sample
);
    logic capture, fetch, commit, fsm_idle;
    logic signed [DW-1:0] in_q, stale, mix;
    logic [KW-1:0] k_q;
    logic pitch_q;
    logic [AW-1:0] wr_ptr, rd_ptr;

    echo_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .capture(capture), .fetch(fetch), .commit(commit), .idle(fsm_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q    <= '0;
            k_q     <= '0;
            pitch_q <= 1'b0;
        end else if (capture) begin
            in_q    <= signed'(in_sample);
            k_q     <= mix_k;
            pitch_q <= pitch_en;
        end
    end

    echo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .pitch(pitch_q), .fetch(fetch),
        .commit(commit), .wdata(mix), .stale(stale),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    echo_mixer #(.DW(DW), .KW(KW)) u_mix (
        .fresh(in_q), .stale(stale), .k(k_q), .mix(mix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= commit;
            if (commit) out_sample <= mix;
        end
    end
endmodule

// File: rtl/echo_ring_chk.sv
module echo_ring_chk #(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic          idle,
    input logic          commit,
    input logic          pitch,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr
);
    logic accept;
    assign accept = rst_n && idle && in_valid;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 out_valid);

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept, 3));

    assert_wr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_ptr) < DEPTH && int'(rd_ptr) < DEPTH);

    assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> int'(wr_ptr) == (int'($past(wr_ptr)) + 1) % DEPTH);

    assert_rd_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && pitch) |=> int'(rd_ptr) == (int'($past(rd_ptr)) + 2) % DEPTH);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(wr_ptr) && $stable(rd_ptr));
endmodule

bind echo_ring echo_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .idle(fsm_idle), .commit(commit), .pitch(pitch_q),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/echo_ring_test.sv
`timescale 1ns/1ps
module echo_ring_test;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [7:0] mix_k = '0;
    logic pitch_en = 1'b0;
    logic out_valid;
    logic [15:0] out_sample;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int mem_m [D];
    int wp = 0;
    int rp = 0;

    always #2 clk = ~clk;

    echo_ring #(.SAMPLE_HZ(1000), .DELAY_MS(6)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .mix_k(mix_k), .pitch_en(pitch_en), .out_valid(out_valid),
        .out_sample(out_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int blend(input int s, input int k, input int old);
        int acc, r;
        acc = s * k + old * (256 - k) + 128;
        r = acc >>> 8;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int model_step(input int s, input int k, input bit p);
        int old, res;
        old = p ? mem_m[rp] : mem_m[wp];
        res = blend(s, k, old);
        mem_m[wp] = res;
        rp = p ? (rp + 2) % D : (wp + 1) % D;
        wp = (wp + 1) % D;
        return res;
    endfunction

    // one sample, exact-latency check (R2) and value check under req
    task automatic send(input int s, input int k, input bit p, input string req);
        int exp;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        in_valid = 1'b1; in_sample = 16'(s); mix_k = 8'(k); pitch_en = p;
        @(negedge clk);
        in_valid = 1'b0; mix_k = 8'hA5; pitch_en = ~p;
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        @(negedge clk);
        exp = model_step(s, k, p);
        check(out_valid == 1'b1, "R2", int'(out_valid), 1);
        check(int'(signed'(out_sample)) == exp, req, int'(signed'(out_sample)), exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_sample == 16'd0, "R1", int'(out_sample), 0);
    endtask

    task automatic t_silence;   // R1: first pass blends against zeros
        send(1000, 128, 1'b0, "R1");
        send(-999, 128, 1'b0, "R1");
        send(32767, 255, 1'b0, "R3");
        send(-32768, 255, 1'b0, "R3");
        send(301, 64, 1'b0, "R3");
        send(7, 1, 1'b0, "R3");
    endtask

    task automatic t_recirc;    // R4/R5: wrap and re-read own results
        send(0, 0, 1'b0, "R4");
        send(0, 0, 1'b0, "R4");
        send(20000, 200, 1'b0, "R4");
        send(-20000, 100, 1'b0, "R4");
        send(12345, 128, 1'b0, "R5");
        send(-1, 255, 1'b0, "R5");
        send(500, 0, 1'b0, "R5");
    endtask

    task automatic t_weight;    // R6: weight changes per sample
        for (int i = 0; i < 4; i++) send(4000 - i * 3000, 60 * i + 15, 1'b0, "R6");
    endtask

    task automatic t_busy;      // R7
        int exp;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(2222); mix_k = 8'd90; pitch_en = 1'b0;
        @(negedge clk);
        in_sample = 16'(-5555); mix_k = 8'd255; pitch_en = 1'b1;
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        @(negedge clk);
        in_sample = 16'(9999);
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        exp = model_step(2222, 90, 1'b0);
        check(int'(signed'(out_sample)) == exp, "R7", int'(signed'(out_sample)), exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        send(100, 10, 1'b0, "R7");
    endtask

    task automatic t_idle;      // R9
        int seen;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, "R9", seen, 0);
        send(-3000, 40, 1'b0, "R9");
    endtask

    task automatic t_pitch;     // R8
        for (int i = 0; i < 9; i++) send(1500 * i - 6000, 160, 1'b1, "R8");
        send(800, 128, 1'b0, "R8");
        send(-800, 128, 1'b0, "R8");
    endtask

    initial begin
        t_reset();
        t_silence();
        t_recirc();
        t_weight();
        t_busy();
        t_idle();
        t_pitch();
        t_recirc();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule